// File: doc/BRIEF.md
# Display control register decoder

This block sits on the control port of a display pipeline. It takes 32-bit control words from a valid/ready stream and keeps the display configuration up to date: the display start position, the horizontal and vertical display ranges, the video mode and the status word. From these registers it works out the visible picture width and height. It also answers information queries by returning fields of the drawing environment registers, which the command-stream parser supplies on an input port. When it receives a reset or a buffer-flush command, it sends one-cycle pulses to the neighbouring blocks.

Each control word carries a command number in bits 31:24 and a parameter in bits 23:0. A write is accepted in any cycle where `wr_valid` and `wr_ready` are both high. A write to a range or mode register schedules a recompute of the picture size. While the recompute is pending or running, `busy` is high and `wr_ready` is low, which holds off the producer. The producer must keep `wr_valid` and `wr_data` stable until the word is accepted. The width needs a division by 2560, which a bit-serial divider performs. The height is combinational arithmetic registered in one cycle.

Top module: `dispctl_top`

## Requirements
- R1: A word is accepted only in a cycle where `wr_valid` and `wr_ready` are both high. An accepted, non-ignored command 0x06, 0x07 or 0x08 drives `wr_ready` low from the next cycle until the picture size is recomputed. Other commands leave `wr_ready` high.
- R2: Command 0x00 does the following. It sets `status` to 0x14802000, `width` to 256, `height` to 240 and `query_data` to 0. It clears the stored parameters of commands 0x02–0x08, except command 0x03, which it sets to 1. In the cycle after acceptance, it raises both `reset_pulse` and `flush_pulse` for one cycle. Hardware reset gives the same state, and it also clears the start position and the ranges.
- R3: Command 0x01 raises `flush_pulse` for one cycle in the cycle after acceptance. It does not raise `reset_pulse`.
- R4: Command 0x03 copies parameter bit 0 into status bit 23 (blanking). Command 0x04 copies parameter bits 1:0 into status bits 30:29 (transfer direction).
- R5: Command 0x05 loads `disp_x` from parameter bits 9:0 and `disp_y` from parameter bits 19:10.
- R6: Command 0x06 loads x1 from parameter bits 11:0 and x2 from bits 23:12. Let d = x2−x1. If d ≤ 0 or d ≥ 2560, `width` becomes the horizontal resolution and `busy` lasts exactly one cycle. Otherwise `width` becomes floor(d·hres/2560) and `busy` lasts between 2 and 32 cycles. Whenever `busy` is low, `width` is valid and ≤ 640.
- R7: Command 0x07 loads y1 from parameter bits 9:0 and y2 from bits 19:10. Let h = y2−y1, doubled when status bit 19 is set. If h > 0, `height` becomes h; otherwise `height` becomes the vertical resolution.
- R8: Command 0x08 writes parameter bits 5:0 into status bits 22:17 and parameter bit 6 into status bit 16. It then recomputes both width and height. The horizontal resolution is indexed by status bits 18:16 from {256,368,320,384,512,512,640,640}. The vertical resolution is indexed by status bits 20:19 from {240,480,256,480}.
- R9: Commands 0x10–0x1F load `query_data` according to the low nibble n. For n = 2..5, the value is the low 20 bits of environment register n. For n = 6, it is environment register 5. For n = 7, it is 2. For any other n, it is 0. `env_fields` packs registers 2..5 as 20-bit fields, with register k at bits (k−2)·20 upward.
- R10: A command 0x02–0x08, other than 0x05, whose parameter equals the last stored parameter of that command is ignored, so it does not raise `busy`. Commands 0x00, 0x01 and 0x05 always act.
- R11: Commands 0x02, 0x09–0x0F and 0x20–0xFF change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Control word present |
| wr_ready | output | 1 | Block can accept a word |
| wr_data | input | 32 | Command [31:24], parameter [23:0] |
| env_fields | input | 80 | Low 20 bits of environment registers 2..5 |
| status | output | 32 | Status word |
| disp_x | output | 10 | Display start x |
| disp_y | output | 10 | Display start y |
| width | output | 10 | Visible width |
| height | output | 12 | Visible height |
| busy | output | 1 | Size recompute pending or running |
| query_data | output | 32 | Info-query read-back |
| reset_pulse | output | 1 | One-cycle reset request |
| flush_pulse | output | 1 | One-cycle flush request |

## Verification
The width path is tested with ranges of exactly 2560, just under 2560, one pixel, and negative. These cases separate the direct path from the divider path and expose off-by-one errors at the limit. The modes are stepped through several resolution indices, including ones with double height. This shows whether the status bits feed the lookup at the right positions and whether the height doubles. Queries sweep every low nibble, and each environment field carries a distinct value, so a swapped slice is visible. Repeated identical writes of commands 0x06 and 0x01 show whether the ignore rule applies to the right commands.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  localparam int CMD_W     = 8;
  localparam int PARAM_W   = 24;
  localparam int COORD_W   = 10;
  localparam int RANGE_W   = 12;
  localparam int WIDTH_W   = 10;
  localparam int HEIGHT_W  = 12;
  localparam int ENV_FLD_W = 20;
  localparam int ENV_CNT   = 4;
  localparam int PROD_W    = RANGE_W + WIDTH_W;
  localparam logic [31:0] STATUS_INIT = 32'h1480_2000;

  localparam int B_BLANK   = 23;
  localparam int B_DIR_LO  = 29;
  localparam int B_DOUBLEH = 19;
  localparam int B_MODE_LO = 16;

  function automatic logic [WIDTH_W-1:0] hres_lookup(input logic [2:0] idx);
    case (idx)
      3'd0:       hres_lookup = 10'd256;
      3'd1:       hres_lookup = 10'd368;
      3'd2:       hres_lookup = 10'd320;
      3'd3:       hres_lookup = 10'd384;
      3'd4, 3'd5: hres_lookup = 10'd512;
      default:    hres_lookup = 10'd640;
    endcase
  endfunction

  function automatic logic [WIDTH_W-1:0] vres_lookup(input logic [1:0] idx);
    case (idx)
      2'd0:    vres_lookup = 10'd240;
      2'd2:    vres_lookup = 10'd256;
      default: vres_lookup = 10'd480;
    endcase
  endfunction
endpackage

// File: rtl/dispctl_div.sv
module dispctl_div #(
  parameter int N_W     = 22,
  parameter int D_W     = 12,
  parameter int Q_W     = 10,
  parameter int DIVISOR = 2560
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  output logic           busy,
  output logic           done,
  output logic [Q_W-1:0] quotient
);
  localparam int CNT_W = $clog2(N_W + 1);
  localparam logic [D_W:0] DIV_V = (D_W + 1)'(DIVISOR);

  logic [CNT_W-1:0] cnt_q;
  logic [N_W-1:0]   acc_q;
  logic [D_W-1:0]   rem_q;
  logic [D_W:0]     trial;
  logic             take;

  assign trial = {rem_q, acc_q[N_W-1]};
  assign take  = (trial >= DIV_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      rem_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt_q <= CNT_W'(N_W);
        acc_q <= dividend;
        rem_q <= '0;
      end else if (cnt_q != '0) begin
        rem_q <= take ? D_W'(trial - DIV_V) : D_W'(trial);
        acc_q <= {acc_q[N_W-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        done  <= (cnt_q == CNT_W'(1));
      end
    end
  end

  assign busy     = (cnt_q != '0);
  assign quotient = acc_q[Q_W-1:0];

  a_r6_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (rem_q < DIV_V[D_W-1:0]));
endmodule

// File: rtl/dispctl_query.sv
module dispctl_query #(
  parameter int FLD_W = 20,
  parameter int N     = 4
) (
  input  logic [3:0]         sel,
  input  logic [N*FLD_W-1:0] fields,
  output logic [31:0]        value
);
  localparam int FIRST = 2;

  always_comb begin
    value = '0;
    for (int k = 0; k < N; k++) begin
      if (sel == 4'(k + FIRST)) value = 32'(fields[k*FLD_W +: FLD_W]);
    end
    if (sel == 4'(N + FIRST))     value = 32'(fields[(N-1)*FLD_W +: FLD_W]);
    if (sel == 4'(N + FIRST + 1)) value = 32'd2;
  end
endmodule

// File: rtl/dispctl_top.sv
module dispctl_top
  import dispctl_pkg::*;
#(
  parameter int SPAN_DIV = 2560
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [31:0]                   wr_data,
  input  logic [ENV_CNT*ENV_FLD_W-1:0]  env_fields,
  output logic [31:0]                   status,
  output logic [COORD_W-1:0]            disp_x,
  output logic [COORD_W-1:0]            disp_y,
  output logic [WIDTH_W-1:0]            width,
  output logic [HEIGHT_W-1:0]           height,
  output logic                          busy,
  output logic [31:0]                   query_data,
  output logic                          reset_pulse,
  output logic                          flush_pulse
);
  localparam int DIV_W = $clog2(SPAN_DIV + 1);
  localparam int SH_LO = 2;
  localparam int SH_HI = 8;

  logic [CMD_W-1:0]   cmd;
  logic [PARAM_W-1:0] prm;
  logic               accept, same, act;
  logic [PARAM_W-1:0] shadow_q [SH_LO:SH_HI];
  logic [RANGE_W-1:0] x1_q, x2_q;
  logic [COORD_W-1:0] y1_q, y2_q;
  logic               pend_q;
  logic               div_busy, div_done;
  logic [WIDTH_W-1:0] div_q;
  logic [WIDTH_W-1:0] hres_cur, vres_cur;
  logic signed [13:0] span_w, span_h, span_h2;
  logic               w_direct;
  logic [PROD_W-1:0]  product;
  logic [HEIGHT_W-1:0] h_calc;
  logic [31:0]        qval;

  assign cmd    = wr_data[31:24];
  assign prm    = wr_data[23:0];
  assign accept = wr_valid && wr_ready;

  always_comb begin
    same = 1'b0;
    for (int i = SH_LO; i <= SH_HI; i++) begin
      if (i != 5 && cmd == CMD_W'(i) && shadow_q[i] == prm) same = 1'b1;
    end
  end
  assign act = accept && !same;

  assign hres_cur = hres_lookup(status[B_MODE_LO+2:B_MODE_LO]);
  assign vres_cur = vres_lookup(status[20:19]);

  assign span_w   = $signed({2'b00, x2_q}) - $signed({2'b00, x1_q});
  assign w_direct = (span_w <= 14'sd0) || (span_w >= $signed(14'(SPAN_DIV)));
  assign product  = PROD_W'(span_w[RANGE_W-1:0]) * PROD_W'(hres_cur);

  assign span_h  = $signed({4'b0000, y2_q}) - $signed({4'b0000, y1_q});
  assign span_h2 = status[B_DOUBLEH] ? (span_h <<< 1) : span_h;
  assign h_calc  = (span_h2 <= 14'sd0) ? HEIGHT_W'(vres_cur) : span_h2[HEIGHT_W-1:0];

  dispctl_div #(
    .N_W(PROD_W), .D_W(DIV_W), .Q_W(WIDTH_W), .DIVISOR(SPAN_DIV)
  ) u_div (
    .clk(clk), .rst_n(rst_n),
    .start(pend_q && !w_direct),
    .dividend(product),
    .busy(div_busy), .done(div_done), .quotient(div_q)
  );

  dispctl_query #(.FLD_W(ENV_FLD_W), .N(ENV_CNT)) u_query (
    .sel(cmd[3:0]), .fields(env_fields), .value(qval)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status      <= STATUS_INIT;
      disp_x      <= '0;
      disp_y      <= '0;
      x1_q        <= '0;
      x2_q        <= '0;
      y1_q        <= '0;
      y2_q        <= '0;
      width       <= WIDTH_W'(256);
      height      <= HEIGHT_W'(240);
      query_data  <= '0;
      pend_q      <= 1'b0;
      reset_pulse <= 1'b0;
      flush_pulse <= 1'b0;
      for (int i = SH_LO; i <= SH_HI; i++) shadow_q[i] <= (i == 3) ? PARAM_W'(1) : '0;
    end else begin
      reset_pulse <= act && (cmd == 8'h00);
      flush_pulse <= act && (cmd == 8'h00 || cmd == 8'h01);
      if (pend_q) begin
        pend_q <= 1'b0;
        height <= h_calc;
        if (w_direct) width <= hres_cur;
      end
      if (div_done) width <= div_q;
      if (act) begin
        for (int i = SH_LO; i <= SH_HI; i++) begin
          if (cmd == CMD_W'(i)) shadow_q[i] <= prm;
        end
        case (cmd)
          8'h00: begin
            status     <= STATUS_INIT;
            width      <= WIDTH_W'(256);
            height     <= HEIGHT_W'(240);
            query_data <= '0;
            for (int i = SH_LO; i <= SH_HI; i++) shadow_q[i] <= (i == 3) ? PARAM_W'(1) : '0;
          end
          8'h03: status[B_BLANK] <= prm[0];
          8'h04: status[B_DIR_LO+1:B_DIR_LO] <= prm[1:0];
          8'h05: begin
            disp_x <= prm[9:0];
            disp_y <= prm[19:10];
          end
          8'h06: begin
            x1_q   <= prm[11:0];
            x2_q   <= prm[23:12];
            pend_q <= 1'b1;
          end
          8'h07: begin
            y1_q   <= prm[9:0];
            y2_q   <= prm[19:10];
            pend_q <= 1'b1;
          end
          8'h08: begin
            status[22:17]     <= prm[5:0];
            status[B_MODE_LO] <= prm[6];
            pend_q            <= 1'b1;
          end
          default: if (cmd[7:4] == 4'h1) query_data <= qval;
        endcase
      end
    end
  end

  assign busy     = pend_q || div_busy || div_done;
  assign wr_ready = !busy;

  a_r2_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd == 8'h00) |=> (status == STATUS_INIT && width == 10'd256 && height == 12'd240));
  a_r3_flush_only: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd == 8'h01) |=> (flush_pulse && !reset_pulse));
  a_r4_blank_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd == 8'h03) |=> (status[B_BLANK] == $past(wr_data[0])));
  a_r9_query_const: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd == 8'h17) |=> (query_data == 32'd2));
  a_r6_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (width <= 10'd640));
  a_r5_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && cmd == 8'h05) |=> $stable(disp_x));
endmodule

// File: tb/dispctl_top_tb.sv
`timescale 1ns/1ps
module dispctl_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [19:0] env_v [4];
  logic [79:0] env_fields;
  logic [31:0] status, query_data;
  logic [9:0]  disp_x, disp_y, width;
  logic [11:0] height;
  logic        busy, reset_pulse, flush_pulse;

  always #2.5 clk = ~clk;

  assign env_fields = {env_v[3], env_v[2], env_v[1], env_v[0]};

  dispctl_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .env_fields(env_fields), .status(status),
    .disp_x(disp_x), .disp_y(disp_y), .width(width), .height(height),
    .busy(busy), .query_data(query_data), .reset_pulse(reset_pulse),
    .flush_pulse(flush_pulse)
  );

  int errs = 0, checks = 0;
  int busy_cnt = 0;
  bit mon_en = 0;
  logic ready_after;
  logic [31:0] m_status, m_q;
  int m_x, m_y, m_w, m_h, m_x1, m_x2, m_y1, m_y2;
  logic [23:0] m_sh [2:8];
  bit e_rst = 0, e_fl = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int hres_f(int i);
    int t[8] = '{256, 368, 320, 384, 512, 512, 640, 640};
    return t[i];
  endfunction
  function automatic int vres_f(int i);
    int t[4] = '{240, 480, 256, 480};
    return t[i];
  endfunction

  function automatic void recompute();
    int sw, sh, hr;
    hr = hres_f(int'(m_status[18:16]));
    sw = m_x2 - m_x1;
    m_w = (sw <= 0 || sw >= 2560) ? hr : (sw * hr) / 2560;
    sh = m_y2 - m_y1;
    if (m_status[19]) sh = sh * 2;
    m_h = (sh <= 0) ? vres_f(int'(m_status[20:19])) : sh;
  endfunction

  function automatic void model_reset_regs();
    m_status = 32'h1480_2000; m_w = 256; m_h = 240; m_q = 0;
    for (int i = 2; i <= 8; i++) m_sh[i] = (i == 3) ? 24'd1 : 24'd0;
  endfunction

  function automatic void model_write(logic [31:0] d);
    int c;
    logic [23:0] p;
    c = int'(d[31:24]);
    p = d[23:0];
    if (c >= 2 && c <= 8 && c != 5 && m_sh[c] == p) return;
    if (c >= 2 && c <= 8) m_sh[c] = p;
    case (c)
      0: begin model_reset_regs(); e_rst = 1; e_fl = 1; end
      1: e_fl = 1;
      3: m_status[23] = p[0];
      4: m_status[30:29] = p[1:0];
      5: begin m_x = int'(p[9:0]); m_y = int'(p[19:10]); end
      6: begin m_x1 = int'(p[11:0]); m_x2 = int'(p[23:12]); recompute(); end
      7: begin m_y1 = int'(p[9:0]); m_y2 = int'(p[19:10]); recompute(); end
      8: begin m_status[22:17] = p[5:0]; m_status[16] = p[6]; recompute(); end
      default: if (c >= 16 && c <= 31) begin
        int n;
        n = c - 16;
        if (n >= 2 && n <= 5) m_q = 32'(env_v[n-2]);
        else if (n == 6) m_q = 32'(env_v[3]);
        else if (n == 7) m_q = 32'd2;
        else m_q = 0;
      end
    endcase
  endfunction

  always @(negedge clk) if (busy) busy_cnt++;

  always @(negedge clk) if (mon_en) begin
    chk("R4 status", status, m_status);
    chk("R5 disp_x", 32'(disp_x), 32'(m_x));
    chk("R5 disp_y", 32'(disp_y), 32'(m_y));
    chk("R9 query", query_data, m_q);
    chk("R2 reset_pulse", 32'(reset_pulse), 32'(e_rst));
    chk("R3 flush_pulse", 32'(flush_pulse), 32'(e_fl));
    if (!busy) begin
      chk("R6 width", 32'(width), 32'(m_w));
      chk("R7 height", 32'(height), 32'(m_h));
    end
  end

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_data = d; wr_valid = 1'b1;
    @(posedge clk);
    #1 wr_valid = 1'b0;
    model_write(d);
    busy_cnt = 0;
    @(negedge clk);
    ready_after = wr_ready;
    @(posedge clk);
    #1 e_rst = 0; e_fl = 0;
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    errs++; checks++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    env_v[0] = 20'hA1B2C; env_v[1] = 20'h3D4E5; env_v[2] = 20'hF0F0F; env_v[3] = 20'h12345;
    m_x = 0; m_y = 0; m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0;
    model_reset_regs();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset status", status, 32'h1480_2000);
    chk("R2 reset width", 32'(width), 32'd256);
    chk("R1 ready after reset", 32'(wr_ready), 32'd1);
    mon_en = 1;

    wr(32'h0300_0000);
    chk("R1 ready stays high", 32'(ready_after), 32'd1);
    wr(32'h0400_0002);
    wr(32'h0500_0000 | (50 << 10) | 100);
    // R6: span exactly 2560 takes the direct path
    wr(32'h0600_0000 | (3168 << 12) | 608);
    chk("R6 direct busy cycles", 32'(busy_cnt), 32'd1);
    chk("R1 ready low after range write", 32'(ready_after), 32'd0);
    wr(32'h0600_0000 | (3167 << 12) | 608);
    checks++;
    if (busy_cnt < 2 || busy_cnt > 32) begin
      errs++; $display("FAIL R6 divide busy: actual %0d expected 2..32", busy_cnt);
    end
    chk("R6 divide result", 32'(width), 32'd255);
    // R10: identical range write is ignored
    wr(32'h0600_0000 | (3167 << 12) | 608);
    chk("R10 repeat no busy", 32'(ready_after), 32'd1);
    wr(32'h0600_0000 | (100 << 12) | 200);
    wr(32'h0600_0000 | (1 << 12));
    chk("R6 one pixel", 32'(width), 32'd0);
    wr(32'h0600_0000 | (1000 << 12) | 40);
    // R8 modes
    wr(32'h0800_0001);
    chk("R8 hres 320 width", 32'(width), 32'(960 * 320 / 2560));
    wr(32'h0800_0040);
    wr(32'h0800_0007);
    chk("R8 mode bits", status, m_status);
    wr(32'h0700_0000 | (256 << 10) | 16);
    chk("R7 doubled", 32'(height), 32'd480);
    wr(32'h0800_0008);
    wr(32'h0700_0000 | (10 << 10) | 300);
    chk("R7 negative uses vres", 32'(height), 32'd256);
    wr(32'h0800_001F);
    wr(32'h0600_0000 | (2000 << 12) | 500);
    // R9 queries over every nibble
    for (int n = 0; n < 16; n++) wr(32'h1000_0000 | (n << 24) | 24'h00ABCD);
    wr(32'h1600_0000);
    chk("R9 query 6", query_data, 32'(env_v[3]));
    // R11 no-effect commands
    wr(32'h0900_1234);
    wr(32'h2012_3456);
    wr(32'hFFFF_FFFF);
    wr(32'h0200_0777);
    chk("R11 status unchanged", status, m_status);
    // R10: commands 0x01 and 0x05 always act
    wr(32'h0100_0000);
    wr(32'h0100_0000);
    wr(32'h0500_0000 | (50 << 10) | 100);
    wr(32'h0300_0001);
    // R2 command reset
    wr(32'h0000_0000);
    chk("R2 cmd reset status", status, 32'h1480_2000);
    chk("R2 cmd reset height", 32'(height), 32'd240);
    wr(32'h0300_0001);
    chk("R10 reg3 preset ignore", 32'(ready_after), 32'd1);
    wr(32'h0600_0000 | (1300 << 12) | 20);
    repeat (3) @(negedge clk);
    mon_en = 0;
    finish_run();
  end
endmodule